// File: doc/BRIEF.md
# SDR SDRAM Start-Up and Refresh Scheduler

This block takes a single-rank, 16-bit SDR SDRAM (4 banks, 13 row bits, 9 column bits) from power-up to its working state. It then keeps the array alive with periodic auto-refresh. After reset it holds the device in a no-operation wait with the clock enable high. It then closes every bank, runs a burst of auto-refresh commands and loads a fixed mode word. When the mode-load recovery time has passed, it raises `ready`.

Two start-up flavours are chosen by a pin that is sampled during reset. The short flavour waits 100 µs and needs at least two start-up refreshes. The long flavour waits 200 µs and needs at least eight. A second pin, also sampled in reset, may ask for more refreshes than the minimum. All delays are given in nanoseconds and turned into clock counts at elaboration from a clock-frequency parameter.

In operation an interval counter raises `ref_req` once per refresh period. The surrounding access logic answers with `ref_gnt` when the banks are closed. The block then issues an auto-refresh on the next clock and drops `ready` for the refresh recovery time.

Top module: `sdr_init_refresh`

## Requirements
- R1: While `rst_n` is low, `sd_cke` is 0, the command pins {cs_n,ras_n,cas_n,we_n} are 1111 (inhibit), `sd_ba` and `sd_addr` are 0, and `ready` and `ref_req` are 0.
- R2: After reset is released, the block drives exactly W consecutive NOP cycles (pins 0111) with `sd_cke` high before its first command. W = ceil(100000 ns · CLK_HZ / 1e9) when `long_init` was 0 in reset, and ceil(200000 ns · CLK_HZ / 1e9) when it was 1.
- R3: The first command after the wait is PRECHARGE ALL (pins 0010) with address bit 10 at 1, all other address bits 0 and bank 0.
- R4: After the precharge, exactly N AUTO REFRESH commands (pins 0001) are issued. N = max(`init_refs`, 2) in the short flavour and max(`init_refs`, 8) in the long flavour, with `init_refs` sampled in reset.
- R5: After the last start-up refresh, exactly one LOAD MODE (pins 0000) is issued with bank 0 and address 0x023. This means burst length 8 in bits [2:0] = 011, sequential ordering in bit 3 = 0, and CAS latency 2 in bits [6:4] = 010.
- R6: The next command follows a precharge after exactly ceil(tRP · CLK_HZ / 1e9) cycles, and follows each refresh after exactly ceil(tRFC · CLK_HZ / 1e9) cycles. Each count is at least 1 and is masked to the timer width.
- R7: `ready` rises exactly TMRD clock cycles after the LOAD MODE cycle, with only NOPs in between.
- R8: Once `ready` first rises, `ref_req` rises every P = floor(tREFI · CLK_HZ / 1e9) cycles, counted from that first rise and from each previous rise. A grant that comes late does not move this schedule.
- R9: `ref_req` stays high, and no command other than NOP is issued, until `ref_gnt` is seen high. The AUTO REFRESH then appears on the following clock, and `ref_req` drops with it.
- R10: A refresh issued in operation holds `ready` low for exactly ceil(tRFC · CLK_HZ / 1e9) cycles, starting with the refresh cycle.
- R11: Once `sd_cke` has gone high after reset, it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| long_init | input | 1 | Start-up flavour, sampled in reset: 0 short, 1 long |
| init_refs | input | REFS_W | Requested start-up refresh count, sampled in reset |
| ref_gnt | input | 1 | Permission to issue the pending refresh |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | AW | Row/column address bus |
| ready | output | 1 | Device initialized and not in refresh recovery |
| ref_req | output | 1 | Refresh due, waiting for grant |

## Verification
The bench builds the block with CLK_HZ at 100 MHz and keeps the default nanosecond values. This gives a 10000-cycle and a 20000-cycle power-up wait, a precharge gap of 2, a refresh gap of 8 and a refresh period of 781 cycles. With these values both start-up flavours fit in one short run. So do the clamping of the requested refresh count in each flavour and a count above the minimum. Grant delays from zero up to half a period show that a late grant leaves the refresh schedule where it was.

// File: rtl/sdr_seq_pkg.sv
// Package: shared command type, state type, mode word and the
// nanosecond-to-cycle conversion used by the start-up sequencer.
package sdr_seq_pkg;

    typedef enum logic [2:0] {
        K_INH,
        K_NOP,
        K_PRE,
        K_REF,
        K_MRS
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        S_PWR,
        S_PRE_W,
        S_REF_W,
        S_MRS_W,
        S_RUN,
        S_AREF_W
    } seq_state_e;

    // Mode word fields: burst length 8, sequential, CAS latency 2
    localparam logic [2:0] MW_BURST8 = 3'b011;
    localparam logic       MW_SEQ    = 1'b0;
    localparam logic [2:0] MW_CL2    = 3'b010;

    // Converts a time in ns to clock cycles, rounded up or down, at least 1,
    // masked to the given counter width.
    function automatic logic [31:0] ns_to_cyc(input longint unsigned ns,
                                              input longint unsigned hz,
                                              input bit              up,
                                              input int unsigned     w);
        longint unsigned prod;
        longint unsigned c;
        prod = ns * hz;
        if (up) c = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        else    c = prod / 64'd1_000_000_000;
        if (c == 64'd0) c = 64'd1;
        c = c & ((64'd1 << w) - 64'd1);
        return c[31:0];
    endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
// Module: down-counting gap timer. Loads a value on request (or its reset
// value while in reset), counts to zero and reports done at zero.
// Assumes the loader never asks for a load while a gap is still running.
module sdr_gap_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Count down toward zero; reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= rst_val;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // A nonzero load must hold the gap open on the next cycle
    assert_load_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !done);

endmodule

// File: rtl/sdr_refresh_pacer.sv
// Module: refresh interval counter. Free-runs while the device is in
// operation, raises a pending request every PERIOD cycles and holds it
// until the sequencer reports the refresh was issued. The count is not
// stalled by a pending request.
module sdr_refresh_pacer #(
    parameter int W      = 12,
    parameter int PERIOD = 703
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic req
);
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt_q;
    logic         pend_q;

    // Interval counter, restarted whenever the device is not in operation
    always_ff @(posedge clk) begin
        if (!rst_n || !run)    cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    // Pending flag: set at each period end, cleared once serviced
    always_ff @(posedge clk) begin
        if (!rst_n || !run)                pend_q <= 1'b0;
        else if (run && cnt_q == LAST)     pend_q <= 1'b1;
        else if (clr)                      pend_q <= 1'b0;
    end

    assign req = pend_q;

    // A pending request only goes away when serviced
    assert_req_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr && run) |=> pend_q);

endmodule

// File: rtl/sdr_cmd_drive.sv
// Module: registered pin driver. Turns a command kind into the clock
// enable, the four command strobes and the address/bank values. Holds
// CKE low and the bus inhibited while in reset.
module sdr_cmd_drive
    import sdr_seq_pkg::*;
#(
    parameter int              AW    = 13,
    parameter int              BA_W  = 2,
    parameter int              AP    = 10,
    parameter logic [AW-1:0]   MWORD = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  sdr_cmd_e        kind,
    output logic            cke,
    output logic [3:0]      pins,
    output logic [BA_W-1:0] ba,
    output logic [AW-1:0]   addr
);
    localparam logic [AW-1:0] ALLBANK = AW'(1) << AP;

    // Register the pin image for the chosen command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke  <= 1'b0;
            pins <= 4'b1111;
            ba   <= '0;
            addr <= '0;
        end else begin
            cke  <= 1'b1;
            ba   <= '0;
            addr <= '0;
            case (kind)
                K_NOP:   pins <= 4'b0111;
                K_PRE: begin
                    pins <= 4'b0010;
                    addr <= ALLBANK;
                end
                K_REF:   pins <= 4'b0001;
                K_MRS: begin
                    pins <= 4'b0000;
                    addr <= MWORD;
                end
                default: pins <= 4'b1111;
            endcase
        end
    end

    // The first cycle with CKE high carries a NOP
    assert_wake_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> pins == 4'b0111);

endmodule

// File: rtl/sdr_init_refresh.sv
// Module: SDR SDRAM start-up and refresh sequencer (top). Runs the
// power-up wait, precharge-all, start-up refreshes and mode load, then
// services periodic refresh under a grant handshake. Assumes the access
// logic has closed every bank before it raises ref_gnt.
module sdr_init_refresh
    import sdr_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 90_000_000,
    parameter int              TMR_W      = 16,
    parameter int              REF_W      = 12,
    parameter int              REFS_W     = 4,
    parameter int              AW         = 13,
    parameter int              BA_W       = 2,
    parameter longint unsigned WAIT_S_NS  = 100_000,
    parameter longint unsigned WAIT_L_NS  = 200_000,
    parameter longint unsigned TRP_NS     = 20,
    parameter longint unsigned TRFC_NS    = 80,
    parameter int              TMRD_CLK   = 2,
    parameter longint unsigned TREFI_NS   = 7_812,
    parameter int              MIN_REF_S  = 2,
    parameter int              MIN_REF_L  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              long_init,
    input  logic [REFS_W-1:0] init_refs,
    input  logic              ref_gnt,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [AW-1:0]     sd_addr,
    output logic              ready,
    output logic              ref_req
);
    localparam logic [TMR_W-1:0] WAIT_S = TMR_W'(ns_to_cyc(WAIT_S_NS, CLK_HZ, 1'b1, TMR_W));
    localparam logic [TMR_W-1:0] WAIT_L = TMR_W'(ns_to_cyc(WAIT_L_NS, CLK_HZ, 1'b1, TMR_W));
    localparam logic [TMR_W-1:0] TRP_C  = TMR_W'(ns_to_cyc(TRP_NS,    CLK_HZ, 1'b1, TMR_W));
    localparam logic [TMR_W-1:0] TRFC_C = TMR_W'(ns_to_cyc(TRFC_NS,   CLK_HZ, 1'b1, TMR_W));
    localparam logic [TMR_W-1:0] TMRD_C = TMR_W'(TMRD_CLK);
    localparam int               REF_P  = int'(ns_to_cyc(TREFI_NS, CLK_HZ, 1'b0, REF_W));
    localparam logic [REFS_W-1:0] MINS  = REFS_W'(MIN_REF_S);
    localparam logic [REFS_W-1:0] MINL  = REFS_W'(MIN_REF_L);
    localparam logic [AW-1:0]    MWORD  = AW'({MW_CL2, MW_SEQ, MW_BURST8});
    localparam int               APOS   = 10;

    seq_state_e        st_q, st_d;
    sdr_cmd_e          kind;
    logic [REFS_W-1:0] left_q, left_d;
    logic [REFS_W-1:0] floor_n, want_n;
    logic              rdy_q, rdy_d;
    logic              ld;
    logic [TMR_W-1:0]  ld_val;
    logic [TMR_W-1:0]  wait_val;
    logic              gap_done;
    logic              serve;
    logic              in_run;
    logic [3:0]        pins;

    // Reset-time choice of wait length and start-up refresh count
    always_comb begin
        wait_val = long_init ? WAIT_L : WAIT_S;
        floor_n  = long_init ? MINL : MINS;
        want_n   = (init_refs < floor_n) ? floor_n : init_refs;
    end

    // Next-state, command and timer-load decision for the sequence
    always_comb begin
        st_d   = st_q;
        kind   = K_NOP;
        ld     = 1'b0;
        ld_val = '0;
        left_d = left_q;
        rdy_d  = rdy_q;
        serve  = 1'b0;
        case (st_q)
            S_PWR: if (gap_done) begin
                kind   = K_PRE;
                ld     = 1'b1;
                ld_val = TRP_C - 1'b1;
                st_d   = S_PRE_W;
            end
            S_PRE_W: if (gap_done) begin
                kind   = K_REF;
                ld     = 1'b1;
                ld_val = TRFC_C - 1'b1;
                left_d = left_q - 1'b1;
                st_d   = S_REF_W;
            end
            S_REF_W: if (gap_done) begin
                ld = 1'b1;
                if (left_q != '0) begin
                    kind   = K_REF;
                    ld_val = TRFC_C - 1'b1;
                    left_d = left_q - 1'b1;
                end else begin
                    kind   = K_MRS;
                    ld_val = TMRD_C - 1'b1;
                    st_d   = S_MRS_W;
                end
            end
            S_MRS_W: if (gap_done) begin
                rdy_d = 1'b1;
                st_d  = S_RUN;
            end
            S_RUN: if (ref_req && ref_gnt) begin
                kind   = K_REF;
                ld     = 1'b1;
                ld_val = TRFC_C - 1'b1;
                rdy_d  = 1'b0;
                serve  = 1'b1;
                st_d   = S_AREF_W;
            end
            S_AREF_W: if (gap_done) begin
                rdy_d = 1'b1;
                st_d  = S_RUN;
            end
            default: st_d = S_PWR;
        endcase
    end

    // State, remaining start-up refreshes and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_PWR;
            left_q <= want_n;
            rdy_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            left_q <= left_d;
            rdy_q  <= rdy_d;
        end
    end

    assign in_run = (st_q == S_RUN) || (st_q == S_AREF_W);
    assign ready  = rdy_q;

    sdr_gap_timer #(.W(TMR_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_val  (wait_val),
        .load     (ld),
        .load_val (ld_val),
        .done     (gap_done)
    );

    sdr_refresh_pacer #(.W(REF_W), .PERIOD(REF_P)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_run),
        .clr   (serve),
        .req   (ref_req)
    );

    sdr_cmd_drive #(.AW(AW), .BA_W(BA_W), .AP(APOS), .MWORD(MWORD)) u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .cke   (sd_cke),
        .pins  (pins),
        .ba    (sd_ba),
        .addr  (sd_addr)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;

    // Clock enable never drops once raised
    assert_cke_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke |=> sd_cke);

    // No mode load may appear while the block claims to be ready
    assert_mrs_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> !ready);

    // A refresh in operation takes ready down with it
    assert_aref_drops_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0001 && $past(ready)) |-> !ready);

    // Ready only rises on a NOP cycle
    assert_ready_rise_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> pins == 4'b0111);

endmodule

// File: tb/tb_sdr_init_refresh.sv
module tb_sdr_init_refresh;
    localparam longint unsigned HZ = 100_000_000;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          long_init = 1'b0;
    logic [RW-1:0] init_refs = '0;
    logic          ref_gnt = 1'b0;
    logic          sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]    sd_ba;
    logic [12:0]   sd_addr;
    logic          ready, ref_req;
    logic [3:0]    pins;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    sdr_init_refresh #(.CLK_HZ(HZ)) dut (
        .clk(clk), .rst_n(rst_n), .long_init(long_init), .init_refs(init_refs),
        .ref_gnt(ref_gnt), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .ready(ready), .ref_req(ref_req)
    );

    function automatic int cyc_up(longint unsigned ns);
        longint unsigned v = (ns * HZ + 64'd999_999_999) / 64'd1_000_000_000;
        return (v == 0) ? 1 : int'(v);
    endfunction
    function automatic int cyc_dn(longint unsigned ns);
        longint unsigned v = (ns * HZ) / 64'd1_000_000_000;
        return (v == 0) ? 1 : int'(v);
    endfunction

    localparam logic [3:0] P_NOP = 4'b0111, P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic next_cmd(output int gap, output logic [3:0] c);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (pins == P_NOP && gap < 100000);
        c = pins;
    endtask

    task automatic run_case(input bit lg, input int refs);
        int nop, gap, nref, cnt, rise_t, d, lows, want, tw;
        logic [3:0] c;
        bit cke_ok, hold_ok;
        long_init = lg;
        init_refs = RW'(refs);
        ref_gnt = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(sd_cke == 0 && pins == 4'b1111 && sd_addr == 0 && sd_ba == 0 && !ready && !ref_req,
            "R1 reset state", int'({sd_cke, pins, ready, ref_req}), 'b0111100);
        rst_n = 1'b1;
        // R2 / R11: NOP wait with CKE high
        nop = 0;
        cke_ok = 1'b1;
        forever begin
            @(negedge clk);
            if (!sd_cke) cke_ok = 1'b0;
            if (pins == P_NOP && nop < 100000) nop++;
            else break;
        end
        tw = cyc_up(lg ? 200_000 : 100_000);
        chk(nop == tw, "R2 wait length", nop, tw);
        chk(pins == P_PRE && sd_addr == 13'h400 && sd_ba == 0, "R3 precharge all", int'(sd_addr), 'h400);
        next_cmd(gap, c);
        chk(gap == cyc_up(20), "R6 tRP gap", gap, cyc_up(20));
        chk(c == P_REF, "R4 first refresh", int'(c), int'(P_REF));
        nref = 1;
        forever begin
            next_cmd(gap, c);
            if (!sd_cke) cke_ok = 1'b0;
            chk(gap == cyc_up(80), "R6 tRFC gap", gap, cyc_up(80));
            if (c == P_REF && nref < 64) nref++;
            else break;
        end
        want = lg ? ((refs < 8) ? 8 : refs) : ((refs < 2) ? 2 : refs);
        chk(nref == want, "R4 start-up refresh count", nref, want);
        chk(c == P_MRS && sd_addr == 13'h023 && sd_ba == 0, "R5 mode load word", int'(sd_addr), 'h23);
        cnt = 0;
        hold_ok = 1'b1;
        do begin
            @(negedge clk);
            cnt++;
            if (!ready && pins != P_NOP) hold_ok = 1'b0;
        end while (!ready && cnt < 1000);
        chk(cnt == 2 && hold_ok, "R7 ready after tMRD", cnt, 2);
        rise_t = cyc;
        while (!ref_req && cyc - rise_t < 5000) @(negedge clk);
        chk(cyc - rise_t == cyc_dn(7812), "R8 first refresh request", cyc - rise_t, cyc_dn(7812));
        rise_t = cyc;
        for (int r = 0; r < 4; r++) begin
            if (r == 0) d = 0;
            else if (r == 1) d = cyc_dn(7812) / 2;
            else d = $urandom_range(cyc_dn(7812) / 2, 1);
            hold_ok = 1'b1;
            for (int k = 0; k < d; k++) begin
                @(negedge clk);
                if (!ref_req || pins != P_NOP) hold_ok = 1'b0;
            end
            chk(hold_ok, "R9 request held without grant", d, d);
            ref_gnt = 1'b1;
            @(negedge clk);
            ref_gnt = 1'b0;
            chk(pins == P_REF && !ref_req, "R9 refresh after grant", int'(pins), int'(P_REF));
            lows = ready ? 0 : 1;
            forever begin
                @(negedge clk);
                if (!ready && lows < 1000) lows++;
                else break;
            end
            chk(lows == cyc_up(80), "R10 ready low after refresh", lows, cyc_up(80));
            while (!ref_req && cyc - rise_t < 5000) @(negedge clk);
            chk(cyc - rise_t == cyc_dn(7812), "R8 refresh period", cyc - rise_t, cyc_dn(7812));
            rise_t = cyc;
        end
        chk(cke_ok && sd_cke, "R11 cke held high", int'(sd_cke), 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        run_case(1'b0, 0);
        run_case(1'b0, 5);
        run_case(1'b1, 3);
        run_case(1'b1, int'($urandom_range(15, 9)));
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc == 150000 && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog all-R act=%0d exp=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule